// File: doc/BRIEF.md
# Microcoded Sequencer With Dispatch ROM

This block is the control unit of a small 8-bit processor. It takes the opcode held in the instruction register and the four ALU status flags. From these it produces one wide horizontal control word per clock cycle. A micro-program counter (micro-PC) addresses a microcode ROM. The word that ROM returns holds the datapath control bits and a small sequencing section. That section decides where the micro-PC goes next: to the next address, to a branch target when a selected flag is set, to a start address looked up from the opcode, or back to the fetch routine.

Lookup works in two levels. The opcode indexes a dispatch ROM, and each dispatch entry is a micro-address. A separate microcode ROM then runs the routine that starts at that address. An opcode with no routine has the all-ones micro-address as its dispatch entry. The trap routine lives at that address and redirects the processor to its trap vector. Both ROMs are computed inside the design from its parameters and package constants. The datapath that the control bits drive is outside this block.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the micro-PC is cleared to 0. The word at address 0 asserts control bit 0 (address from PC) and control bit 1 (memory read).
- R2: With `stall` low, a word whose sequencing code is 00 (next) moves the micro-PC to the current address plus one.
- R3: With `stall` low, sequencing code 01 (branch) loads the word's target field if the flag chosen by its select field is 1. Otherwise it moves to the current address plus one. Select values are 0 = zero, 1 = negative, 2 = positive, 3 = carry, and they match `flags` bits 0 to 3.
- R4: With `stall` low, sequencing code 10 (dispatch) loads the dispatch entry for the present `opcode`. The defined entries are: 0x00→0x008, 0x01→0x010, 0x02→0x020, 0x03→0x030, and 0x10+k→0x040+16·k for k = 0..3.
- R5: For any other opcode, the dispatch entry is 0x3FF, so a dispatch moves the micro-PC to 0x3FF.
- R6: The word at 0x3FF asserts control bit 15 (trap) and has sequencing code 11.
- R7: With `stall` low, sequencing code 11 (fetch) moves the micro-PC to 0.
- R8: While `stall` is high at a rising edge, the micro-PC and the emitted word do not change.
- R9: The word at the entry of opcode 0x10+k is a branch with select field k and target entry+3.
- R10: The fetch routine is three words: addresses 0 and 1 use code 00, and address 2 uses code 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Holds the micro-PC while high |
| opcode | input | 8 | Opcode from the instruction register |
| flags | input | 4 | ALU flags: bit0 zero, bit1 negative, bit2 positive, bit3 carry |
| upc | output | 10 | Current micro-PC |
| uword | output | 30 | Current microword: [29:14] control, [13:12] sequencing code, [11:10] flag select, [9:0] branch target |

## Verification
The bench uses the default parameters: an 8-bit opcode, 10-bit micro-addresses, 16 control bits and four flags. With these defaults, every dispatch entry, the trap address at 0x3FF and all four flag-select branch routines can be reached in a short run. Random opcodes cover all 256 values, so undefined opcodes are dispatched often. Random flags and stalls make branches both taken and not taken, and they put stalls on dispatch, branch and return cycles. A mid-run reset checks that the block restarts from fetch.

// File: rtl/ucseq_pkg.sv
// Package: shared encodings of the microcoded sequencer.
// Assumes the control word is at least 16 bits wide and that the micro-address
// is wide enough (at least 8 bits) to hold every routine entry below.
package ucseq_pkg;

    // sequencing section of each microword
    typedef enum logic [1:0] {
        SEQ_NEXT     = 2'b00,
        SEQ_BRANCH   = 2'b01,
        SEQ_DISPATCH = 2'b10,
        SEQ_FETCH    = 2'b11
    } seq_op_t;

    // flag positions on the flags input, also the flag-select values
    localparam int FLG_ZERO = 0;
    localparam int FLG_NEG  = 1;
    localparam int FLG_POS  = 2;
    localparam int FLG_CARRY = 3;

    // control bit positions inside the control section
    localparam int CB_ADDR_PC = 0;
    localparam int CB_MEM_RD  = 1;
    localparam int CB_IR_LD   = 2;
    localparam int CB_PC_INC  = 3;
    localparam int CB_ALU_GO  = 4;
    localparam int CB_REG_WR  = 5;
    localparam int CB_MEM_WR  = 6;
    localparam int CB_PC_LD   = 7;
    localparam int CB_OPND_LD = 8;
    localparam int CB_TRAP    = 15;

    // defined opcodes
    localparam int OP_NOP   = 8'h00;
    localparam int OP_LDI   = 8'h01;
    localparam int OP_ADD   = 8'h02;
    localparam int OP_STA   = 8'h03;
    localparam int OP_JBASE = 8'h10;

    // routine entry micro-addresses
    localparam int UA_FETCH   = 0;
    localparam int UA_NOP     = 8;
    localparam int UA_LDI     = 16;
    localparam int UA_ADD     = 32;
    localparam int UA_STA     = 48;
    localparam int UA_JBASE   = 64;
    localparam int UA_JSTRIDE = 16;
    localparam int UA_JTAKEN  = 3;

endpackage

// File: rtl/ucseq_dispatch_rom.sv
// Module: dispatch ROM, the first lookup level.
// It maps an opcode straight to the micro-address where that opcode's routine
// starts. Opcodes without a routine map to the all-ones address, where the
// trap routine sits. The contents are computed from package constants.
// Assumes the conditional-branch family holds FLAG_N opcodes in a row.
module ucseq_dispatch_rom
    import ucseq_pkg::*;
#(
    parameter int OPC_W   = 8,
    parameter int UADDR_W = 10,
    parameter int FLAG_N  = 4
) (
    input  logic [OPC_W-1:0]   opcode,
    output logic [UADDR_W-1:0] entry
);

    localparam logic [UADDR_W-1:0] TRAP_UA = {UADDR_W{1'b1}};

    logic [FLAG_N-1:0]  jhit;
    logic [UADDR_W-1:0] jentry [FLAG_N];
    logic [UADDR_W-1:0] base_entry;

    // one decoder and one entry per conditional-branch opcode
    generate
        for (genvar k = 0; k < FLAG_N; k++) begin : g_jfam
            assign jhit[k]   = (opcode == OPC_W'(OP_JBASE + k));
            assign jentry[k] = UADDR_W'(UA_JBASE + k * UA_JSTRIDE);
        end
    endgenerate

    // entries for the single opcodes, with trap as the fallback
    always_comb begin
        case (opcode)
            OPC_W'(OP_NOP): base_entry = UADDR_W'(UA_NOP);
            OPC_W'(OP_LDI): base_entry = UADDR_W'(UA_LDI);
            OPC_W'(OP_ADD): base_entry = UADDR_W'(UA_ADD);
            OPC_W'(OP_STA): base_entry = UADDR_W'(UA_STA);
            default:        base_entry = TRAP_UA;
        endcase
    end

    // a branch-family hit overrides the single-opcode result
    always_comb begin
        entry = base_entry;
        for (int k = 0; k < FLAG_N; k++) begin
            if (jhit[k]) entry = jentry[k];
        end
    end

endmodule

// File: rtl/ucseq_ucode_rom.sv
// Module: horizontal microcode ROM, the second lookup level.
// It returns the microword for an address: control bits, sequencing code,
// flag select and branch target. Routines: fetch (0..2), single-opcode
// routines, one branch routine per flag, and the trap word at the last
// address. Every other address holds a word that returns to fetch and
// drives no control bits.
module ucseq_ucode_rom
    import ucseq_pkg::*;
#(
    parameter int UADDR_W = 10,
    parameter int CTRL_W  = 16,
    parameter int FLAG_N  = 4,
    localparam int FSEL_W = $clog2(FLAG_N)
) (
    input  logic [UADDR_W-1:0] uaddr,
    output logic [CTRL_W-1:0]  ctrl,
    output seq_op_t            seq,
    output logic [FSEL_W-1:0]  fsel,
    output logic [UADDR_W-1:0] target
);

    localparam logic [UADDR_W-1:0] TRAP_UA = {UADDR_W{1'b1}};

    // returns a control word with the listed bit set
    function automatic logic [CTRL_W-1:0] cb(input int pos);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[pos] = 1'b1;
        return w;
    endfunction

    // microword contents, computed from address
    always_comb begin
        ctrl   = '0;
        seq    = SEQ_FETCH;
        fsel   = '0;
        target = '0;
        case (uaddr)
            // fetch: put PC on the address bus, read, load IR, then dispatch
            UADDR_W'(UA_FETCH + 0): begin
                ctrl = cb(CB_ADDR_PC) | cb(CB_MEM_RD);
                seq  = SEQ_NEXT;
            end
            UADDR_W'(UA_FETCH + 1): begin
                ctrl = cb(CB_IR_LD) | cb(CB_PC_INC);
                seq  = SEQ_NEXT;
            end
            UADDR_W'(UA_FETCH + 2): begin
                seq  = SEQ_DISPATCH;
            end
            // no-operation
            UADDR_W'(UA_NOP): begin
                seq  = SEQ_FETCH;
            end
            // load immediate: read operand byte, write register
            UADDR_W'(UA_LDI + 0): begin
                ctrl = cb(CB_ADDR_PC) | cb(CB_MEM_RD);
                seq  = SEQ_NEXT;
            end
            UADDR_W'(UA_LDI + 1): begin
                ctrl = cb(CB_REG_WR) | cb(CB_PC_INC);
                seq  = SEQ_FETCH;
            end
            // add immediate: operand read, ALU, write back
            UADDR_W'(UA_ADD + 0): begin
                ctrl = cb(CB_ADDR_PC) | cb(CB_MEM_RD) | cb(CB_OPND_LD);
                seq  = SEQ_NEXT;
            end
            UADDR_W'(UA_ADD + 1): begin
                ctrl = cb(CB_ALU_GO) | cb(CB_PC_INC);
                seq  = SEQ_NEXT;
            end
            UADDR_W'(UA_ADD + 2): begin
                ctrl = cb(CB_REG_WR);
                seq  = SEQ_FETCH;
            end
            // store absolute: two address bytes, then memory write
            UADDR_W'(UA_STA + 0): begin
                ctrl = cb(CB_ADDR_PC) | cb(CB_MEM_RD) | cb(CB_OPND_LD);
                seq  = SEQ_NEXT;
            end
            UADDR_W'(UA_STA + 1): begin
                ctrl = cb(CB_PC_INC);
                seq  = SEQ_NEXT;
            end
            UADDR_W'(UA_STA + 2): begin
                ctrl = cb(CB_ADDR_PC) | cb(CB_MEM_RD) | cb(CB_OPND_LD);
                seq  = SEQ_NEXT;
            end
            UADDR_W'(UA_STA + 3): begin
                ctrl = cb(CB_MEM_WR) | cb(CB_PC_INC);
                seq  = SEQ_FETCH;
            end
            // trap: load the trap vector into PC, then refetch
            TRAP_UA: begin
                ctrl = cb(CB_TRAP) | cb(CB_PC_LD);
                seq  = SEQ_FETCH;
            end
            default: begin
                seq  = SEQ_FETCH;
            end
        endcase
        // conditional-branch routines, one per flag
        for (int k = 0; k < FLAG_N; k++) begin
            if (uaddr == UADDR_W'(UA_JBASE + k * UA_JSTRIDE)) begin
                ctrl   = cb(CB_ADDR_PC) | cb(CB_MEM_RD);
                seq    = SEQ_BRANCH;
                fsel   = FSEL_W'(k);
                target = UADDR_W'(UA_JBASE + k * UA_JSTRIDE + UA_JTAKEN);
            end else if (uaddr == UADDR_W'(UA_JBASE + k * UA_JSTRIDE + 1)) begin
                ctrl   = cb(CB_PC_INC);
                seq    = SEQ_NEXT;
            end else if (uaddr == UADDR_W'(UA_JBASE + k * UA_JSTRIDE + 2)) begin
                ctrl   = cb(CB_PC_INC);
                seq    = SEQ_FETCH;
            end else if (uaddr == UADDR_W'(UA_JBASE + k * UA_JSTRIDE + UA_JTAKEN)) begin
                ctrl   = cb(CB_OPND_LD) | cb(CB_PC_INC);
                seq    = SEQ_NEXT;
            end else if (uaddr == UADDR_W'(UA_JBASE + k * UA_JSTRIDE + UA_JTAKEN + 1)) begin
                ctrl   = cb(CB_PC_LD);
                seq    = SEQ_FETCH;
            end
        end
    end

endmodule

// File: rtl/ucseq_next_addr.sv
// Module: next micro-address selection.
// It picks the next micro-PC from the sequencing code of the current word:
// increment, conditional branch on a selected flag, dispatch entry, or fetch.
// Assumes the flag-select field indexes the flags vector directly.
module ucseq_next_addr
    import ucseq_pkg::*;
#(
    parameter int UADDR_W = 10,
    parameter int FLAG_N  = 4,
    localparam int FSEL_W = $clog2(FLAG_N)
) (
    input  logic [UADDR_W-1:0] cur,
    input  seq_op_t            seq,
    input  logic [FSEL_W-1:0]  fsel,
    input  logic [UADDR_W-1:0] target,
    input  logic [FLAG_N-1:0]  flags,
    input  logic [UADDR_W-1:0] disp_entry,
    output logic [UADDR_W-1:0] nxt
);

    logic [FLAG_N-1:0] sel_hit;
    logic              take;
    logic [UADDR_W-1:0] incr;

    // one select-and-test term per flag
    generate
        for (genvar k = 0; k < FLAG_N; k++) begin : g_ftest
            assign sel_hit[k] = (fsel == FSEL_W'(k)) && flags[k];
        end
    endgenerate

    assign take = |sel_hit;
    assign incr = cur + 1'b1;

    // next-address multiplexer
    always_comb begin
        case (seq)
            SEQ_NEXT:     nxt = incr;
            SEQ_BRANCH:   nxt = take ? target : incr;
            SEQ_DISPATCH: nxt = disp_entry;
            default:      nxt = UADDR_W'(UA_FETCH);
        endcase
    end

endmodule

// File: rtl/ucode_sequencer.sv
// Module: microcoded sequencer top.
// It holds the micro-PC and connects the dispatch ROM, the microcode ROM and
// the next-address logic. The emitted microword comes from the current
// micro-PC with no pipeline stage. Reset is synchronous, active low.
// Assumes opcode and flags are stable during the cycle in which a dispatch
// or branch word is active.
module ucode_sequencer
    import ucseq_pkg::*;
#(
    parameter int OPC_W   = 8,
    parameter int UADDR_W = 10,
    parameter int CTRL_W  = 16,
    parameter int FLAG_N  = 4,
    localparam int FSEL_W = $clog2(FLAG_N),
    localparam int WORD_W = CTRL_W + 2 + FSEL_W + UADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FLAG_N-1:0]  flags,
    output logic [UADDR_W-1:0] upc,
    output logic [WORD_W-1:0]  uword
);

    localparam logic [UADDR_W-1:0] TRAP_UA = {UADDR_W{1'b1}};

    logic [UADDR_W-1:0] upc_q;
    logic [UADDR_W-1:0] upc_d;
    logic [UADDR_W-1:0] disp_entry;
    logic [CTRL_W-1:0]  ctrl;
    seq_op_t            seq;
    logic [FSEL_W-1:0]  fsel;
    logic [UADDR_W-1:0] target;

    ucseq_dispatch_rom #(
        .OPC_W   (OPC_W),
        .UADDR_W (UADDR_W),
        .FLAG_N  (FLAG_N)
    ) u_disp (
        .opcode (opcode),
        .entry  (disp_entry)
    );

    ucseq_ucode_rom #(
        .UADDR_W (UADDR_W),
        .CTRL_W  (CTRL_W),
        .FLAG_N  (FLAG_N)
    ) u_rom (
        .uaddr  (upc_q),
        .ctrl   (ctrl),
        .seq    (seq),
        .fsel   (fsel),
        .target (target)
    );

    ucseq_next_addr #(
        .UADDR_W (UADDR_W),
        .FLAG_N  (FLAG_N)
    ) u_next (
        .cur        (upc_q),
        .seq        (seq),
        .fsel       (fsel),
        .target     (target),
        .flags      (flags),
        .disp_entry (disp_entry),
        .nxt        (upc_d)
    );

    // micro-PC register: clear on reset, hold on stall, else advance
    always_ff @(posedge clk) begin
        if (!rst_n)      upc_q <= UADDR_W'(UA_FETCH);
        else if (!stall) upc_q <= upc_d;
    end

    // outputs: current address and the word it selects
    assign upc   = upc_q;
    assign uword = {ctrl, seq, fsel, target};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> upc_q == UADDR_W'(UA_FETCH));

    // R2
    next_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !stall && seq == SEQ_NEXT)
        |=> upc_q == UADDR_W'($past(upc_q) + 1'b1));

    // R3
    branch_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !stall && seq == SEQ_BRANCH && flags[fsel])
        |=> upc_q == $past(target));

    // R3
    branch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !stall && seq == SEQ_BRANCH && !flags[fsel])
        |=> upc_q == UADDR_W'($past(upc_q) + 1'b1));

    // R4
    dispatch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !stall && seq == SEQ_DISPATCH)
        |=> upc_q == $past(disp_entry));

    // R6
    trap_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_q == TRAP_UA) |-> (ctrl[CB_TRAP] && seq == SEQ_FETCH));

    // R7
    fetch_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !stall && seq == SEQ_FETCH)
        |=> upc_q == UADDR_W'(UA_FETCH));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && stall) |=> ($stable(upc_q) && $stable(uword)));

endmodule

// File: tb/ucode_sequencer_tb.sv
`timescale 1ns/1ps
module ucode_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [3:0]  flags = 4'h0;
    logic [9:0]  upc;
    logic [29:0] uword;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;

    always #2.5 clk = ~clk;

    ucode_sequencer u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (stall),
        .opcode (opcode),
        .flags  (flags),
        .upc    (upc),
        .uword  (uword)
    );

    // field views of the observed microword
    wire [15:0] w_ctrl = uword[29:14];
    wire [1:0]  w_seq  = uword[13:12];
    wire [1:0]  w_fsel = uword[11:10];
    wire [9:0]  w_tgt  = uword[9:0];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // expected dispatch entry from the opcode table
    function automatic logic [9:0] exp_entry(input logic [7:0] op);
        case (op)
            8'h00: return 10'h008;
            8'h01: return 10'h010;
            8'h02: return 10'h020;
            8'h03: return 10'h030;
            8'h10: return 10'h040;
            8'h11: return 10'h050;
            8'h12: return 10'h060;
            8'h13: return 10'h070;
            default: return 10'h3FF;
        endcase
    endfunction

    function automatic logic [7:0] pick_op(input int unsigned r);
        logic [7:0] defined_ops [8] = '{8'h00, 8'h01, 8'h02, 8'h03,
                                        8'h10, 8'h11, 8'h12, 8'h13};
        if (r[3:0] < 4'd9) return defined_ops[r[6:4]];
        return 8'(r >> 8);
    endfunction

    // checks on the content of the word at well-known addresses
    task automatic content_checks();
        if (upc == 10'h000) begin
            chk(w_ctrl[0] && w_ctrl[1], "R1", 32'(w_ctrl), 32'h3);
            chk(w_seq == 2'b00, "R10", 32'(w_seq), 32'h0);
        end
        if (upc == 10'h001) chk(w_seq == 2'b00, "R10", 32'(w_seq), 32'h0);
        if (upc == 10'h002) chk(w_seq == 2'b10, "R10", 32'(w_seq), 32'h2);
        if (upc == 10'h3FF) begin
            chk(w_ctrl[15] == 1'b1, "R6", 32'(w_ctrl[15]), 32'h1);
            chk(w_seq == 2'b11, "R6", 32'(w_seq), 32'h3);
        end
        for (int k = 0; k < 4; k++) begin
            if (upc == 10'(10'h040 + 16 * k)) begin
                chk(w_seq == 2'b01, "R9", 32'(w_seq), 32'h1);
                chk(w_fsel == 2'(k), "R9", 32'(w_fsel), 32'(k));
                chk(w_tgt == 10'(10'h043 + 16 * k), "R9", 32'(w_tgt), 32'(10'h043 + 16 * k));
            end
        end
    endtask

    // watchdog: a hung run still reaches the summary line
    initial begin
        #(5ns * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [9:0]  exp_upc;
        logic [29:0] prev_word;
        string       tag;
        int unsigned r;
        logic [7:0]  dir_ops [10] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h10,
                                      8'h11, 8'h12, 8'h13, 8'hFF, 8'h3F};
        r = $urandom(32'd20251);

        // reset state
        repeat (3) @(negedge clk);
        chk(upc == 10'h000, "R1", 32'(upc), 32'h0);
        content_checks();
        rst_n   = 1'b1;
        exp_upc = 10'h000;
        tag     = "R1";

        for (int cyc = 0; cyc < 4000; cyc++) begin
            // compare state produced by the last edge
            chk(upc == exp_upc, tag, 32'(upc), 32'(exp_upc));
            if (tag == "R8")
                chk(uword == prev_word, "R8", 32'(uword), 32'(prev_word));
            content_checks();
            prev_word = uword;

            // drive next inputs
            if (cyc < 160) begin
                opcode = dir_ops[(cyc / 5) % 10];
                flags  = 4'(cyc / 3);
                stall  = (cyc % 7 == 5);
                rst_n  = 1'b1;
            end else begin
                r      = $urandom;
                opcode = pick_op(r);
                flags  = 4'($urandom);
                stall  = ($urandom % 5 == 0);
                rst_n  = !(cyc == 2000 || cyc == 3100);
            end

            // expected next micro-PC from the requirements
            if (!rst_n) begin
                exp_upc = 10'h000; tag = "R1";
            end else if (stall) begin
                tag = "R8";
            end else begin
                case (w_seq)
                    2'b00: begin exp_upc = exp_upc + 10'd1; tag = "R2"; end
                    2'b01: begin
                        exp_upc = flags[w_fsel] ? w_tgt : exp_upc + 10'd1;
                        tag = "R3";
                    end
                    2'b10: begin
                        exp_upc = exp_entry(opcode);
                        tag = (exp_upc == 10'h3FF) ? "R5" : "R4";
                    end
                    default: begin exp_upc = 10'h000; tag = "R7"; end
                endcase
            end
            @(posedge clk);
            @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule